// File: doc/BRIEF.md
# Center-Aligned Up/Down PWM Timer

This block is a 16-bit timer that counts up from zero to a programmable turnaround value (TOP) and then back down to zero, over and over. Each of three compare channels watches the count and drives one PWM pin. The pin changes level once on the way up and once on the way down, so each pulse sits centred on the bottom of the count. The count moves only on cycles where the timer-enable input `tick` is high, so a prescaler outside the block sets the rate. The PWM period is 2·TOP enable pulses.

Software writes each compare value into a buffer. The buffer moves into the channel's active register only when the counter is at zero. Rising and falling slopes therefore always use the same value, and every period stays symmetric. TOP comes from one of two places. One is a dedicated period register whose writes take effect at once. The other is channel A's buffered compare value, which lets the period change cleanly between periods. Sticky flags mark the bottom of the count, the top of the count and each channel's compare match. Writing 1 to a flag's clear bit clears it.

The counter is a two-state machine. `SLOPE_RISE` increments the count. On an enabled cycle where the count is nonzero and at or above TOP, it moves to `SLOPE_FALL`. `SLOPE_FALL` decrements the count. On an enabled cycle at count zero, it goes back to `SLOPE_RISE` and the counter steps to 1.

Top module: `cpwm_timer`

## Requirements
- R1: With `tick` high on every enabled cycle, the count after each rising edge follows 0,1,…,TOP,TOP-1,…,1,0,1,… and stays at TOP for exactly one enabled cycle. On a cycle with `tick` low, the count and all other state hold.
- R2: With `top_from_a`=0, TOP is the period register, and a write to it is used from the next cycle on. With `top_from_a`=1, TOP is channel A's compare value.
- R3: A compare write lands in the channel's buffer at once. The active compare value takes the buffer only on an enabled cycle at count 0, and the buffer value already governs the match test on that same cycle.
- R4: An enabled cycle at count 0 sets `bottom_flag` at the next edge.
- R5: An enabled cycle at count TOP sets `top_flag` at the next edge, but only while `top_from_a`=0. With `top_from_a`=1 it is never set.
- R6: An enabled cycle where the count equals channel i's compare value sets `cmp_flag[i]` at that edge. A compare value above TOP never matches.
- R7: Every flag stays set until its bit in `flag_clr` is 1 on a cycle. A set on that same cycle wins over the clear. Clear bit map: bits 0..2 are channels A..C, bit 3 is `bottom_flag`, bit 4 is `top_flag`.
- R8: Channel mode 2 (`pin_mode[2i+1:2i]`=2) drives the pin low on a match while rising and high on a match while falling. A match at count 0 counts as rising. A match at TOP counts as falling.
- R9: Channel mode 3 drives the pin high on a match while rising and low on a match while falling.
- R10: A compare value of 0 holds the pin low in mode 2 and high in mode 3. A compare value equal to TOP holds the pin high in mode 2 after its first match.
- R11: Mode 1 on channel A with `top_from_a`=1 toggles the pin at each match, which is each TOP, giving a 50% square wave. Mode 0, and mode 1 anywhere else, drive the pin low.
- R12: Synchronous reset clears the count, the period register, all buffers, active values and flags, sets the direction to rising, and drives every pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer enable pulse; the count advances only when high |
| top_from_a | input | 1 | 0: TOP from period register; 1: TOP from channel A compare |
| period_we | input | 1 | Write strobe for the period register |
| period_wdata | input | 16 | Period register write data |
| cmp_we | input | 3 | Per-channel compare buffer write strobes (bit 0 = A) |
| cmp_wdata | input | 16 | Compare buffer write data |
| pin_mode | input | 6 | Two-bit output mode per channel, channel A in bits 1:0 |
| flag_clr | input | 5 | Write-one-to-clear strobes for the flags |
| pwm_out | output | 3 | PWM pins, bit 0 = channel A |
| cmp_flag | output | 3 | Sticky compare-match flags |
| bottom_flag | output | 1 | Sticky flag set at count zero |
| top_flag | output | 1 | Sticky flag set at TOP when the period register defines TOP |
| count | output | 16 | Current count |

## Verification
On every cycle, the assertions check the following. The count never moves by more than one step. It stays frozen without `tick`. The direction turns at TOP. The active compare values change only at the bottom. Flags stay set until cleared and always take a set. The bottom flag follows each enabled cycle at zero, and the top flag stays quiet while channel A defines TOP. Duty cycles, constant-level extremes, the square wave of mode 1, the switch of TOP source between periods and the ignored out-of-range compare value show only over whole periods, so the bench's scenarios cover them. It runs the outputs against a period-by-period model under several enable patterns.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic {
        SLOPE_RISE = 1'b0,
        SLOPE_FALL = 1'b1
    } slope_e;

    localparam logic [1:0] PIN_OFF        = 2'd0;
    localparam logic [1:0] PIN_TOGGLE     = 2'd1;
    localparam logic [1:0] PIN_CLR_RISING = 2'd2;
    localparam logic [1:0] PIN_SET_RISING = 2'd3;

endpackage

// File: rtl/cpwm_sticky.sv
module cpwm_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr);
    end

    // R7: a set flag survives every cycle without a clear
    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (q && !clr) |=> q);

    // R7: a set event always wins over a simultaneous clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        set |=> q);

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter import cpwm_pkg::*; #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] top_now,
    output logic [CW-1:0] cnt,
    output logic          at_bottom,
    output logic          at_top,
    output logic          rising
);

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    slope_e        state, state_nxt;
    logic [CW-1:0] cnt_nxt;

    // Next-state and next-count decision
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (tick) begin
            if (cnt == ZERO) begin
                state_nxt = SLOPE_RISE;
                cnt_nxt   = (top_now == ZERO) ? ZERO : ONE;
            end else begin
                unique case (state)
                    SLOPE_RISE: begin
                        if (cnt >= top_now) begin
                            state_nxt = SLOPE_FALL;
                            cnt_nxt   = cnt - ONE;
                        end else begin
                            cnt_nxt   = cnt + ONE;
                        end
                    end
                    SLOPE_FALL: begin
                        cnt_nxt = cnt - ONE;
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= SLOPE_RISE;
        else     state <= state_nxt;
    end

    // Count register
    always_ff @(posedge clk) begin
        if (rst) cnt <= ZERO;
        else     cnt <= cnt_nxt;
    end

    // Outputs decoded from state and count
    always_comb begin
        at_bottom = (cnt == ZERO);
        at_top    = (cnt == top_now);
        rising    = at_bottom || ((state == SLOPE_RISE) && (cnt < top_now));
    end

    // R1: one enabled cycle moves the count by exactly one step or to zero
    assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE) || (cnt == ZERO));

    // R1: without the enable nothing in the counter moves
    assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(cnt) && $stable(state)));

    // R1: leaving TOP on the rise turns the slope downward
    assert_turn_at_top_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && state == SLOPE_RISE && !at_bottom && at_top)
            |=> (state == SLOPE_FALL) && (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel import cpwm_pkg::*; #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic [CW-1:0] cnt,
    input  logic          at_bottom,
    input  logic          rising,
    input  logic [1:0]    pin_mode,
    input  logic          toggle_ok,
    input  logic          flag_clr,
    output logic [CW-1:0] cmp_now,
    output logic          pin,
    output logic          flag
);

    logic [CW-1:0] buf_q;
    logic [CW-1:0] act_q;
    logic          wave_q;
    logic          hit;

    always_ff @(posedge clk) begin
        if (rst)        buf_q <= '0;
        else if (wr_en) buf_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                    act_q <= '0;
        else if (tick && at_bottom) act_q <= buf_q;
    end

    // The value being loaded at the bottom already governs that cycle
    always_comb begin
        cmp_now = at_bottom ? buf_q : act_q;
        hit     = tick && (cnt == cmp_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
        end else if (hit) begin
            unique case (pin_mode)
                PIN_CLR_RISING: wave_q <= ~rising;
                PIN_SET_RISING: wave_q <= rising;
                PIN_TOGGLE:     wave_q <= toggle_ok ? ~wave_q : wave_q;
                default:        wave_q <= wave_q;
            endcase
        end
    end

    always_comb begin
        unique case (pin_mode)
            PIN_CLR_RISING, PIN_SET_RISING: pin = wave_q;
            PIN_TOGGLE:                     pin = toggle_ok & wave_q;
            default:                        pin = 1'b0;
        endcase
    end

    cpwm_sticky u_flag (
        .clk (clk),
        .rst (rst),
        .set (hit),
        .clr (flag_clr),
        .q   (flag)
    );

    // R3: the active compare value changes only on an enabled bottom cycle
    assert_active_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        !(tick && at_bottom) |=> $stable(act_q));

    // R8: the waveform level never moves on a cycle without the enable
    assert_wave_needs_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(wave_q));

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer import cpwm_pkg::*; #(
    parameter int CW  = 16,
    parameter int NCH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             top_from_a,
    input  logic             period_we,
    input  logic [CW-1:0]    period_wdata,
    input  logic [NCH-1:0]   cmp_we,
    input  logic [CW-1:0]    cmp_wdata,
    input  logic [2*NCH-1:0] pin_mode,
    input  logic [NCH+1:0]   flag_clr,
    output logic [NCH-1:0]   pwm_out,
    output logic [NCH-1:0]   cmp_flag,
    output logic             bottom_flag,
    output logic             top_flag,
    output logic [CW-1:0]    count
);

    localparam int BOT_IDX = NCH;
    localparam int TOP_IDX = NCH + 1;

    logic [CW-1:0] period_q;
    logic [CW-1:0] ch_cmp [NCH];
    logic [CW-1:0] top_now;
    logic [CW-1:0] cnt;
    logic          at_bottom;
    logic          at_top;
    logic          rising;

    always_ff @(posedge clk) begin
        if (rst)            period_q <= '0;
        else if (period_we) period_q <= period_wdata;
    end

    always_comb top_now = top_from_a ? ch_cmp[0] : period_q;

    cpwm_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .top_now   (top_now),
        .cnt       (cnt),
        .at_bottom (at_bottom),
        .at_top    (at_top),
        .rising    (rising)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            cpwm_channel #(.CW(CW)) u_ch (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .wr_en     (cmp_we[i]),
                .wr_data   (cmp_wdata),
                .cnt       (cnt),
                .at_bottom (at_bottom),
                .rising    (rising),
                .pin_mode  (pin_mode[2*i +: 2]),
                .toggle_ok ((i == 0) ? top_from_a : 1'b0),
                .flag_clr  (flag_clr[i]),
                .cmp_now   (ch_cmp[i]),
                .pin       (pwm_out[i]),
                .flag      (cmp_flag[i])
            );
        end
    endgenerate

    cpwm_sticky u_bot_flag (
        .clk (clk),
        .rst (rst),
        .set (tick && at_bottom),
        .clr (flag_clr[BOT_IDX]),
        .q   (bottom_flag)
    );

    cpwm_sticky u_top_flag (
        .clk (clk),
        .rst (rst),
        .set (tick && at_top && !top_from_a),
        .clr (flag_clr[TOP_IDX]),
        .q   (top_flag)
    );

    always_comb count = cnt;

    // R4: an enabled cycle at zero is always followed by a raised bottom flag
    assert_bottom_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '0) |=> bottom_flag);

    // R5: the top flag never rises while channel A defines TOP
    assert_top_flag_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (top_from_a && !top_flag) |=> !top_flag);

endmodule

// File: tb/cpwm_timer_bench.sv
`timescale 1ns/1ps
module cpwm_timer_bench;

    typedef struct packed {
        logic        msel;
        logic [15:0] per;
        logic [15:0] ca;
        logic [15:0] cb;
        logic [15:0] cc;
        logic [5:0]  om;
        logic [7:0]  cycles;
        logic [1:0]  tpat;
    } row_t;

    localparam int NROWS = 7;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 16'd8,  16'd3, 16'd0,  16'd8,  6'b10_10_10, 8'd60, 2'd0},
        '{1'b0, 16'd8,  16'd3, 16'd0,  16'd8,  6'b11_11_11, 8'd70, 2'd1},
        '{1'b0, 16'd6,  16'd2, 16'd20, 16'd5,  6'b10_10_10, 8'd60, 2'd2},
        '{1'b1, 16'd0,  16'd5, 16'd2,  16'd4,  6'b10_10_01, 8'd60, 2'd0},
        '{1'b1, 16'd0,  16'd3, 16'd1,  16'd3,  6'b11_10_01, 8'd40, 2'd0},
        '{1'b0, 16'd12, 16'd7, 16'd4,  16'd10, 6'b00_01_10, 8'd60, 2'd1},
        '{1'b0, 16'd4,  16'd4, 16'd1,  16'd2,  6'b10_11_10, 8'd50, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst, tick, msel, per_we;
    logic [15:0] per_d, cd;
    logic [2:0]  cwe;
    logic [5:0]  om;
    logic [4:0]  clr;
    logic [2:0]  pwm_out, cmp_flag;
    logic        bottom_flag, top_flag;
    logic [15:0] count;

    logic [15:0] m_cnt, m_per;
    logic        m_up;
    logic [15:0] m_buf [3];
    logic [15:0] m_act [3];
    logic [2:0]  m_wave, m_cf;
    logic        m_bf, m_tf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cpwm_timer u_cpwm_timer (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .top_from_a   (msel),
        .period_we    (per_we),
        .period_wdata (per_d),
        .cmp_we       (cwe),
        .cmp_wdata    (cd),
        .pin_mode     (om),
        .flag_clr     (clr),
        .pwm_out      (pwm_out),
        .cmp_flag     (cmp_flag),
        .bottom_flag  (bottom_flag),
        .top_flag     (top_flag),
        .count        (count)
    );

    function automatic string tag_of(input int r);
        case (r)
            0: return "R8 R10 non-inverting";
            1: return "R9 R10 inverting, gated enable";
            2: return "R6 compare above TOP";
            3: return "R2 R11 TOP from channel A";
            4: return "R11 minimum TOP";
            5: return "R11 off and ineligible toggle";
            default: return "R3 R1 shorter period";
        endcase
    endfunction

    function automatic logic tick_pat(input logic [1:0] p, input int g);
        case (p)
            2'd0:    return 1'b1;
            2'd1:    return (g % 2) == 0;
            default: return (g % 3) != 0;
        endcase
    endfunction

    function automatic logic [2:0] exp_pins();
        logic [2:0] p;
        for (int i = 0; i < 3; i++) begin
            logic [1:0] md;
            md = om[2*i +: 2];
            if (md >= 2'd2)                      p[i] = m_wave[i];
            else if (md == 2'd1 && i == 0 && msel) p[i] = m_wave[i];
            else                                 p[i] = 1'b0;
        end
        return p;
    endfunction

    // Behavioural expectation derived from the requirements
    task automatic model_step();
        logic [15:0] cn [3];
        logic [15:0] tn;
        logic        rise;
        logic [4:0]  s;
        if (rst) begin
            m_cnt = '0; m_per = '0; m_up = 1'b1;
            m_wave = '0; m_cf = '0; m_bf = 1'b0; m_tf = 1'b0;
            for (int i = 0; i < 3; i++) begin
                m_buf[i] = '0;
                m_act[i] = '0;
            end
            return;
        end
        s = '0;
        for (int i = 0; i < 3; i++) cn[i] = (m_cnt == 16'd0) ? m_buf[i] : m_act[i];
        tn = msel ? cn[0] : m_per;
        if (tick) begin
            rise = (m_cnt == 16'd0) || (m_up && m_cnt < tn);
            for (int i = 0; i < 3; i++) begin
                if (m_cnt == cn[i]) begin
                    s[i] = 1'b1;
                    case (om[2*i +: 2])
                        2'd2: m_wave[i] = ~rise;
                        2'd3: m_wave[i] = rise;
                        2'd1: if (i == 0 && msel) m_wave[i] = ~m_wave[i];
                        default: ;
                    endcase
                end
            end
            if (m_cnt == 16'd0) s[3] = 1'b1;
            if (!msel && m_cnt == tn) s[4] = 1'b1;
            if (m_cnt == 16'd0) begin
                for (int i = 0; i < 3; i++) m_act[i] = m_buf[i];
                m_up  = 1'b1;
                m_cnt = (tn == 16'd0) ? 16'd0 : 16'd1;
            end else if (m_up) begin
                if (m_cnt >= tn) begin
                    m_up  = 1'b0;
                    m_cnt = m_cnt - 16'd1;
                end else begin
                    m_cnt = m_cnt + 16'd1;
                end
            end else begin
                m_cnt = m_cnt - 16'd1;
            end
        end
        m_cf = (m_cf & ~clr[2:0]) | s[2:0];
        m_bf = (m_bf & ~clr[3]) | s[3];
        m_tf = (m_tf & ~clr[4]) | s[4];
        for (int i = 0; i < 3; i++) if (cwe[i]) m_buf[i] = cd;
        if (per_we) m_per = per_d;
    endtask

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        #1;
        check(tag, {count, pwm_out, cmp_flag, bottom_flag, top_flag},
                   {m_cnt, exp_pins(), m_cf, m_bf, m_tf});
    endtask

    task automatic idle_inputs();
        per_we = 1'b0; cwe = '0; clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL R1: watchdog expired");
        finish_run();
    end

    initial begin
        int g;
        g = 0;
        rst = 1'b1; tick = 1'b0; msel = 1'b0; per_d = '0; cd = '0; om = '0;
        idle_inputs();
        cyc("R12 reset");
        cyc("R12 reset");
        check("R12 reset outputs", {count, pwm_out, cmp_flag, bottom_flag, top_flag}, 24'h0);
        rst = 1'b0;

        // Table of scenarios, each compared cycle by cycle
        for (int r = 0; r < NROWS; r++) begin
            row_t v;
            v = ROWS[r];
            for (int c = 0; c < int'(v.cycles); c++) begin
                idle_inputs();
                msel = v.msel;
                om   = v.om;
                if (c == 0) begin
                    per_we = 1'b1; per_d = v.per;
                    cwe = 3'b001; cd = v.ca; clr = '1;
                end else if (c == 1) begin
                    cwe = 3'b010; cd = v.cb;
                end else if (c == 2) begin
                    cwe = 3'b100; cd = v.cc;
                end
                tick = tick_pat(v.tpat, g);
                cyc(tag_of(r));
                g++;
            end
        end

        // R12: reset in mid-run with inverting modes selected
        idle_inputs();
        rst = 1'b1; tick = 1'b1; om = 6'b11_11_11; msel = 1'b0;
        cyc("R12 reset mid-run");
        check("R12 pins low after reset", {count, pwm_out, cmp_flag, bottom_flag, top_flag}, 24'h0);
        rst = 1'b0;

        // R2: period write with the enable low, count stays at zero
        om = '0; tick = 1'b0; per_we = 1'b1; per_d = 16'd4;
        cyc("R2 period write");
        check("R1 hold without enable", {8'h0, count}, 24'h0);
        idle_inputs();

        // R1 R4 R5: literal triangle for TOP = 4
        for (int k = 1; k <= 12; k++) begin
            int p;
            tick = 1'b1;
            cyc("R1 triangle");
            p = k % 8;
            check("R1 count sequence", {8'h0, count}, {8'h0, 16'((p <= 4) ? p : 8 - p)});
            if (k == 1) check("R4 bottom flag", {23'h0, bottom_flag}, 24'h1);
            if (k == 4) check("R5 top flag before TOP", {23'h0, top_flag}, 24'h0);
            if (k == 5) check("R5 top flag after TOP", {23'h0, top_flag}, 24'h1);
        end

        // R7: clear everything with no enable, then set wins over clear
        tick = 1'b0; clr = '1;
        cyc("R7 clear");
        check("R7 all flags cleared", {19'h0, cmp_flag, bottom_flag, top_flag}, 24'h0);
        tick = 1'b1; clr = '1;
        cyc("R7 set wins");
        check("R7 top set beats clear", {count, 3'b0, cmp_flag, bottom_flag, top_flag},
                                        {16'd3, 3'b0, 3'b000, 1'b0, 1'b1});
        idle_inputs();
        tick = 1'b0;
        cyc("R7 idle");

        finish_run();
    end

endmodule